// File: doc/BRIEF.md
# Asynchronous Write Fault Recorder

This block sits beside an I/O bus bridge and records faults from posted writes, which complete on the bus after the issuing agent has moved on. Three causes are watched: an error that the bus reports after a transaction has finished, a write that stays in progress for too long, and an error acknowledge. The second cause is detected inside the block. A counter runs while the bridge holds its write-busy input high, and it fires once when the write exceeds a time limit that is derived from the clock frequency.

When the block is empty, the first fault loads a status word and a fault address register. The status word holds the cause, the transaction size code, the privilege mode, the direction and an address-valid flag. While a fault is held, later faults do not overwrite it. They only raise a multiple-fault flag. Software reads both registers through a small register port and empties the recorder by writing a one to the top status bit.

Top module: `wfault_recorder`

## Requirements
- R1: After reset the status register reads 0x00800000 and the fault address register reads 0.
- R2: Status bits [23:20] always read 0x8, whatever faults or writes have occurred.
- R3: A late-error pulse on an empty recorder sets bits 30 and 31, and captures the size code in bits [27:25], supervisor mode in bit 24 and the read flag in bit 18. It sets bit 17 and loads the fault address register with the transaction address.
- R4: An acknowledge-error pulse on an empty recorder sets bits 28 and 31, and captures the same fields as R3.
- R5: If write-busy is high for LIMIT = CLK_KHZ*TIMEOUT_NS/1000000 consecutive clock edges, bits 29 and 31 are set along with the attributes present at the LIMIT-th edge. If it is high for LIMIT-1 edges and then dropped, nothing is recorded.
- R6: One long write raises the timeout at most once. Dropping write-busy restarts the count.
- R7: A fault that arrives while a fault is held sets bit 19 and leaves every other status bit and the fault address unchanged.
- R8: Faults of several causes in the same cycle on an empty recorder set all of their cause bits and bit 19, and capture the attributes once.
- R9: A write with data bit 31 set to the status register (select 0) clears all bits except the reserved field and zeroes the fault address. A status write with bit 31 clear, or any write to the address register (select 1), has no effect.
- R10: A fault in the same cycle as a clearing write is recorded as a new first fault, with bit 19 clear.
- R11: Read data is registered. It shows the register selected at one clock edge, with the contents held just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_busy | input | 1 | A posted write is in progress on the bus |
| late_err | input | 1 | Error reported after a transaction (one-cycle pulse) |
| ack_err | input | 1 | Error acknowledge received (one-cycle pulse) |
| txn_size | input | 3 | Size code of the current transaction |
| txn_super | input | 1 | Issuer was in supervisor mode |
| txn_read | input | 1 | Current transaction is a read |
| txn_addr | input | ADDR_W | Physical address of the current transaction |
| reg_sel | input | 1 | Register select: 0 status, 1 fault address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
Late errors are swept across every size code, privilege mode and direction, each time with a distinct address. This separates each captured field from its neighbours and shows any bit crossing. Acknowledge errors repeat part of that sweep, which shows the two cause bits are kept apart. Write-busy runs of LIMIT-2, LIMIT-1, LIMIT and a much longer length separate an off-by-one in the timeout counter from a counter that fires more than once. Second faults, simultaneous faults and faults that coincide with a clear separate the multiple-fault flag from first-fault capture. Non-clearing writes confirm that only the one write form empties the recorder.

// File: rtl/wfault_pkg.sv
package wfault_pkg;
  localparam int REG_W = 32;
  localparam logic [3:0] RESV_CODE = 4'h8;

  typedef struct packed {
    logic [2:0] size;
    logic       sup;
    logic       rd;
  } txn_attr_t;

  typedef struct packed {
    logic late;
    logic tmo;
    logic ack;
  } cause_t;
endpackage

// File: rtl/wfault_timer.sv
module wfault_timer
  import wfault_pkg::*;
#(
  parameter int LIMIT  = 320,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  txn_attr_t         attr_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              tmo_pulse,
  output txn_attr_t         tmo_attr,
  output logic [ADDR_W-1:0] tmo_addr
);
  localparam int CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             fired_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      fired_q   <= 1'b0;
      tmo_pulse <= 1'b0;
      tmo_attr  <= '0;
      tmo_addr  <= '0;
    end else begin
      tmo_pulse <= 1'b0;
      if (!busy) begin
        cnt_q   <= '0;
        fired_q <= 1'b0;
      end else if (!fired_q) begin
        if (cnt_q == LAST) begin
          tmo_pulse <= 1'b1;
          fired_q   <= 1'b1;
          tmo_attr  <= attr_in;
          tmo_addr  <= addr_in;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // The timeout can only follow a cycle with the write still busy (R5)
  assert_pulse_needs_busy_R5: assert property (@(posedge clk) disable iff (rst)
    tmo_pulse |-> $past(busy));

  // One pulse per long write (R6)
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    tmo_pulse |=> !tmo_pulse);
endmodule

// File: rtl/wfault_capture.sv
module wfault_capture
  import wfault_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              late_in,
  input  logic              ack_in,
  input  logic              tmo_in,
  input  txn_attr_t         now_attr,
  input  logic [ADDR_W-1:0] now_addr,
  input  txn_attr_t         tmo_attr,
  input  logic [ADDR_W-1:0] tmo_addr,
  input  logic              clr,
  output cause_t            cause_q,
  output txn_attr_t         attr_q,
  output logic              multi_q,
  output logic              valid_q,
  output logic [ADDR_W-1:0] addr_q
);
  logic              any_ev;
  logic              many_ev;
  txn_attr_t         pick_attr;
  logic [ADDR_W-1:0] pick_addr;
  cause_t            new_cause;

  always_comb begin
    new_cause = '{late: late_in, tmo: tmo_in, ack: ack_in};
    any_ev    = late_in | ack_in | tmo_in;
    many_ev   = ($countones({late_in, ack_in, tmo_in}) > 1);
    if (late_in || ack_in) begin
      pick_attr = now_attr;
      pick_addr = now_addr;
    end else begin
      pick_attr = tmo_attr;
      pick_addr = tmo_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      attr_q  <= '0;
      multi_q <= 1'b0;
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else if (any_ev && (clr || !valid_q)) begin
      cause_q <= new_cause;
      attr_q  <= pick_attr;
      addr_q  <= pick_addr;
      multi_q <= many_ev;
      valid_q <= 1'b1;
    end else if (clr) begin
      cause_q <= '0;
      attr_q  <= '0;
      addr_q  <= '0;
      multi_q <= 1'b0;
      valid_q <= 1'b0;
    end else if (any_ev) begin
      multi_q <= 1'b1;
    end
  end

  // A clear with no new fault empties the recorder (R9)
  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (rst)
    (clr && !any_ev) |=> (!valid_q && cause_q == '0));

  // A later fault raises the multiple flag (R7)
  assert_multi_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (valid_q && any_ev && !clr) |=> multi_q);

  // A held fault keeps its captured attributes (R7)
  assert_hold_first_R7: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !clr) |=> ($stable(addr_q) && $stable(attr_q) && $stable(cause_q)));
endmodule

// File: rtl/wfault_regif.sv
module wfault_regif
  import wfault_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic [REG_W-1:0]  wdata,
  input  cause_t            cause,
  input  txn_attr_t         attr,
  input  logic              multi,
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  output logic              clr,
  output logic [REG_W-1:0]  rdata
);
  logic [REG_W-1:0] status_w;
  logic [REG_W-1:0] addr_w;

  always_comb begin
    clr      = wr && !sel && wdata[REG_W-1];
    status_w = {(cause.late | cause.tmo | cause.ack), cause.late, cause.tmo, cause.ack,
                attr.size, attr.sup, RESV_CODE, multi, attr.rd, valid, 17'b0};
    addr_w   = REG_W'(addr);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel ? addr_w : status_w;
  end
endmodule

// File: rtl/wfault_recorder.sv
module wfault_recorder
  import wfault_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CLK_KHZ    = 25000,
  parameter int TIMEOUT_NS = 12800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_busy,
  input  logic              late_err,
  input  logic              ack_err,
  input  logic [2:0]        txn_size,
  input  logic              txn_super,
  input  logic              txn_read,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  localparam int RAW_LIMIT = (CLK_KHZ * TIMEOUT_NS) / 1000000;
  localparam int LIMIT     = (RAW_LIMIT < 2) ? 2 : RAW_LIMIT;

  txn_attr_t         now_attr, tmo_attr, attr_q;
  logic [ADDR_W-1:0] tmo_addr, addr_q;
  logic              tmo_pulse, clr, multi_q, valid_q;
  cause_t            cause_q;

  assign now_attr = '{size: txn_size, sup: txn_super, rd: txn_read};

  wfault_timer #(.LIMIT(LIMIT), .ADDR_W(ADDR_W)) u_timer (
    .clk(clk), .rst(rst), .busy(wr_busy), .attr_in(now_attr), .addr_in(txn_addr),
    .tmo_pulse(tmo_pulse), .tmo_attr(tmo_attr), .tmo_addr(tmo_addr));

  wfault_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk(clk), .rst(rst), .late_in(late_err), .ack_in(ack_err), .tmo_in(tmo_pulse),
    .now_attr(now_attr), .now_addr(txn_addr), .tmo_attr(tmo_attr), .tmo_addr(tmo_addr),
    .clr(clr), .cause_q(cause_q), .attr_q(attr_q), .multi_q(multi_q),
    .valid_q(valid_q), .addr_q(addr_q));

  wfault_regif #(.ADDR_W(ADDR_W)) u_regif (
    .clk(clk), .rst(rst), .sel(reg_sel), .wr(reg_wr), .wdata(reg_wdata),
    .cause(cause_q), .attr(attr_q), .multi(multi_q), .valid(valid_q), .addr(addr_q),
    .clr(clr), .rdata(reg_rdata));
endmodule

// File: tb/test_wfault_recorder.sv
module test_wfault_recorder;
  localparam int CLK_KHZ = 2500;
  localparam int LIMIT   = CLK_KHZ * 12800 / 1000000; // 32 edges

  logic clk = 0, rst = 1;
  logic wr_busy = 0, late_err = 0, ack_err = 0;
  logic [2:0] txn_size = 0;
  logic txn_super = 0, txn_read = 0;
  logic [31:0] txn_addr = 0;
  logic reg_sel = 0, reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  int errors = 0, checks = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  wfault_recorder #(.ADDR_W(32), .CLK_KHZ(CLK_KHZ), .TIMEOUT_NS(12800)) i_wfault_recorder (
    .clk(clk), .rst(rst), .wr_busy(wr_busy), .late_err(late_err), .ack_err(ack_err),
    .txn_size(txn_size), .txn_super(txn_super), .txn_read(txn_read), .txn_addr(txn_addr),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  function automatic logic [31:0] st(bit l, bit t, bit a, logic [2:0] sz, bit s,
                                     bit me, bit r, bit v);
    return {(l | t | a), l, t, a, sz, s, 4'h8, me, r, v, 17'b0};
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(bit sel, output logic [31:0] v);
    @(negedge clk); reg_sel = sel;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic wreg(bit sel, logic [31:0] d);
    @(negedge clk); reg_sel = sel; reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic setattr(logic [2:0] sz, bit s, bit r, logic [31:0] a);
    txn_size = sz; txn_super = s; txn_read = r; txn_addr = a;
  endtask

  task automatic pulse(bit l, bit a);
    @(negedge clk); late_err = l; ack_err = a;
    @(negedge clk); late_err = 0; ack_err = 0;
  endtask

  task automatic busy_run(int n);
    @(negedge clk); wr_busy = 1;
    repeat (n) @(negedge clk);
    wr_busy = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: got hang expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state, R2 reserved field
    rd(0, rv); chk("R1 status", rv, 32'h0080_0000);
    chk("R2 reserved", {28'b0, rv[23:20]}, 32'h8);
    rd(1, rv); chk("R1 addr", rv, 0);

    // R3 sweep: late errors over every size, mode and direction
    for (int i = 0; i < 32; i++) begin
      logic [31:0] a = 32'h1000_0000 + i * 32'h0101_0104;
      setattr(i[2:0], i[3], i[4], a);
      pulse(1, 0);
      rd(0, rv); chk("R3 status", rv, st(1, 0, 0, i[2:0], i[3], 0, i[4], 1));
      rd(1, rv); chk("R3 addr", rv, a);
      wreg(0, 32'h8000_0000);
    end

    // R4 acknowledge errors
    for (int i = 0; i < 8; i++) begin
      logic [31:0] a = 32'hF000_0000 - i * 32'h0033_0010;
      setattr(3'(7 - i), i[0], i[1], a);
      pulse(0, 1);
      rd(0, rv); chk("R4 status", rv, st(0, 0, 1, 3'(7 - i), i[0], 0, i[1], 1));
      rd(1, rv); chk("R4 addr", rv, a);
      wreg(0, 32'h8000_0000);
    end

    // R11 registered read: a selection just made shows the prior state
    setattr(3'd2, 1, 0, 32'hABCD_0000);
    @(negedge clk); reg_sel = 0; late_err = 1;
    @(negedge clk); late_err = 0;
    chk("R11 old value", reg_rdata, 32'h0080_0000);
    @(negedge clk);
    chk("R11 new value", reg_rdata, st(1, 0, 0, 3'd2, 1, 0, 0, 1));

    // R7 a second fault only raises the multiple flag
    setattr(3'd5, 0, 1, 32'h1234_5678);
    pulse(0, 1);
    rd(0, rv); chk("R7 status", rv, st(1, 0, 0, 3'd2, 1, 1, 0, 1));
    rd(1, rv); chk("R7 addr", rv, 32'hABCD_0000);

    // R9 non-clearing writes have no effect
    wreg(0, 32'h7FFF_FFFF);
    wreg(1, 32'hFFFF_FFFF);
    rd(0, rv); chk("R9 no clear status", rv, st(1, 0, 0, 3'd2, 1, 1, 0, 1));
    rd(1, rv); chk("R9 no clear addr", rv, 32'hABCD_0000);
    wreg(0, 32'h8000_0000);
    rd(0, rv); chk("R9 cleared status", rv, 32'h0080_0000);
    rd(1, rv); chk("R9 cleared addr", rv, 0);

    // R8 simultaneous causes
    setattr(3'd6, 1, 1, 32'h0000_BEEF);
    pulse(1, 1);
    rd(0, rv); chk("R8 status", rv, st(1, 0, 1, 3'd6, 1, 1, 1, 1));
    rd(1, rv); chk("R8 addr", rv, 32'h0000_BEEF);

    // R10 fault coincident with a clear becomes a new first fault
    setattr(3'd1, 0, 0, 32'h5555_AAAA);
    @(negedge clk); reg_sel = 0; reg_wr = 1; reg_wdata = 32'h8000_0000; ack_err = 1;
    @(negedge clk); reg_wr = 0; reg_wdata = 0; ack_err = 0;
    rd(0, rv); chk("R10 status", rv, st(0, 0, 1, 3'd1, 0, 0, 0, 1));
    rd(1, rv); chk("R10 addr", rv, 32'h5555_AAAA);
    wreg(0, 32'h8000_0000);

    // R5 timeout boundary sweep
    setattr(3'd3, 1, 0, 32'h0C0F_FEE0);
    for (int n = LIMIT - 3; n < LIMIT; n++) begin
      busy_run(n);
      rd(0, rv); chk("R5 below limit", rv, 32'h0080_0000);
    end
    busy_run(LIMIT);
    rd(0, rv); chk("R5 at limit", rv, st(0, 1, 0, 3'd3, 1, 0, 0, 1));
    rd(1, rv); chk("R5 addr", rv, 32'h0C0F_FEE0);
    wreg(0, 32'h8000_0000);

    // R6 a very long write fires once; a restart counts afresh
    busy_run(4 * LIMIT);
    rd(0, rv); chk("R6 once", rv, st(0, 1, 0, 3'd3, 1, 0, 0, 1));
    wreg(0, 32'h8000_0000);
    busy_run(LIMIT - 1);
    busy_run(LIMIT - 1);
    rd(0, rv); chk("R6 restart", rv, 32'h0080_0000);
    busy_run(LIMIT);
    busy_run(LIMIT);
    rd(0, rv); chk("R6 two writes", rv, st(0, 1, 0, 3'd3, 1, 1, 0, 1));
    chk("R2 reserved after faults", {28'b0, rv[23:20]}, 32'h8);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule